// File: doc/BRIEF.md
# Bidirectional Mailbox Register Pair

This block lets three clock domains trade single words alongside a pair of FIFOs without queuing them. Mailbox 1 carries a word from side A to side B, and mailbox 2 carries a word from side C to side A. On each port a select line steers the access. When the select is high, a write goes into the mailbox, or a read returns the mailbox word. When it is low, the access becomes a FIFO strobe, and read data comes from the FIFO output bus that the port supplies.

Each mailbox has an active-low "mail waiting" flag. The writing clock sets the flag and the reading clock clears it. Set and clear events cross between domains as toggles through two-flop synchronisers, so each port sees a copy of the flag in its own clock. While its flag shows unread mail, a mailbox refuses further writes, so an unread word is never overwritten. Each mailbox has its own active-low asynchronous reset. The user ties this reset to the master and partial resets of the FIFO that belongs to the mailbox.

Top module: `mbox_pair`

## Requirements
- R1: A side-A write (`a_wr_i` high) with `a_mbx_sel_i` high loads `a_wdata_i` into mailbox 1. A side-C write with `c_mbx_sel_i` high loads `c_wdata_i` into mailbox 2.
- R2: On the side-A clock edge that accepts a mailbox 1 write, `mb1_flag_a_no` goes low. Within three side-B clock edges, `mb1_flag_b_no` also goes low. The same holds for mailbox 2: `mb2_flag_c_no` goes low at once and `mb2_flag_a_no` follows within three side-A edges.
- R3: A mailbox write attempted while the writer's copy of the flag is low is ignored. The word already stored is kept and later read out unchanged.
- R4: A side-B read (`b_rd_i` high) with `b_mbx_sel_i` high while mail is waiting returns the mailbox 1 word on `b_rdata_o`. It drives `mb1_flag_b_no` high at that edge. Within three side-A edges, `mb1_flag_a_no` goes high.
- R5: A side-A read with `a_mbx_sel_i` high while mail is waiting returns the mailbox 2 word on `a_rdata_o`. It drives `mb2_flag_a_no` high at that edge. Within three side-C edges, `mb2_flag_c_no` goes high.
- R6: When a port's select is low, its read data equals its FIFO data input (`a_fifo_rdata_i` or `b_fifo_rdata_i`). Mailbox flags are not affected.
- R7: The FIFO strobes are `a_fifo_wr_o = a_wr_i & ~a_mbx_sel_i`, `a_fifo_rd_o = a_rd_i & ~a_mbx_sel_i`, `b_fifo_rd_o = b_rd_i & ~b_mbx_sel_i` and `c_fifo_wr_o = c_wr_i & ~c_mbx_sel_i`. A mailbox-selected access produces no FIFO strobe.
- R8: A mailbox read while no mail is waiting leaves both copies of that mailbox's flag high.
- R9: Driving `mb1_rst_ni` low forces both mailbox 1 flags high at once and leaves the mailbox 2 flags untouched. Driving `mb2_rst_ni` low does the same for mailbox 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Side A clock |
| clk_b_i | input | 1 | Side B clock |
| clk_c_i | input | 1 | Side C clock |
| mb1_rst_ni | input | 1 | Mailbox 1 asynchronous reset, active low |
| mb2_rst_ni | input | 1 | Mailbox 2 asynchronous reset, active low |
| a_wr_i | input | 1 | Side A write strobe |
| a_rd_i | input | 1 | Side A read strobe |
| a_mbx_sel_i | input | 1 | Side A mailbox select |
| a_wdata_i | input | DATA_W | Side A write data |
| a_fifo_rdata_i | input | DATA_W | FIFO output data toward side A |
| a_rdata_o | output | DATA_W | Side A read data |
| a_fifo_wr_o | output | 1 | FIFO write strobe from side A |
| a_fifo_rd_o | output | 1 | FIFO read strobe from side A |
| mb1_flag_a_no | output | 1 | Mailbox 1 waiting flag, side A clock, active low |
| mb2_flag_a_no | output | 1 | Mailbox 2 waiting flag, side A clock, active low |
| b_rd_i | input | 1 | Side B read strobe |
| b_mbx_sel_i | input | 1 | Side B mailbox select |
| b_fifo_rdata_i | input | DATA_W | FIFO output data toward side B |
| b_rdata_o | output | DATA_W | Side B read data |
| b_fifo_rd_o | output | 1 | FIFO read strobe from side B |
| mb1_flag_b_no | output | 1 | Mailbox 1 waiting flag, side B clock, active low |
| c_wr_i | input | 1 | Side C write strobe |
| c_mbx_sel_i | input | 1 | Side C mailbox select |
| c_wdata_i | input | DATA_W | Side C write data |
| c_fifo_wr_o | output | 1 | FIFO write strobe from side C |
| mb2_flag_c_no | output | 1 | Mailbox 2 waiting flag, side C clock, active low |

## Verification
Three unrelated clock periods drive a full round trip on both mailboxes, once for each of several arithmetic data patterns. A design that fails to block a second write would deliver the overwriting word instead of the first one. A mailbox read with no mail waiting is issued on purpose: a design that toggles the clear event anyway would leave the flag stuck low on the writer side, or set it spuriously. FIFO-path accesses run between mailbox operations. A design with a crossed select would raise a FIFO strobe on a mailbox access or move a flag on a FIFO access. Each reset is pulsed separately while both mailboxes hold mail, which exposes a design whose flags share a reset.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  // synchroniser depth for every domain crossing
  parameter int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/mbox_sync.sv
`timescale 1ns/1ps
module mbox_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/mbox_channel.sv
`timescale 1ns/1ps
module mbox_channel
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] mail_o,
  output logic              wflag_no,
  output logic              rflag_no
);
  logic              set_tgl_q, clr_tgl_q;
  logic              set_s, clr_s;
  logic              full_w, full_r;
  logic [DATA_W-1:0] mail_q;

  // writer domain: pending while own toggle differs from echoed clear
  assign full_w = set_tgl_q ^ clr_s;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_tgl_q <= 1'b0;
      mail_q    <= '0;
    end else if (wr_i && !full_w) begin
      set_tgl_q <= ~set_tgl_q;
      mail_q    <= wdata_i;
    end
  end

  mbox_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (clr_tgl_q),
    .q_o   (clr_s)
  );

  // reader domain
  mbox_sync #(.STAGES(SYNC_STAGES)) u_set_sync (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (set_tgl_q),
    .q_o   (set_s)
  );

  assign full_r = set_s ^ clr_tgl_q;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)               clr_tgl_q <= 1'b0;
    else if (rd_i && full_r)   clr_tgl_q <= ~clr_tgl_q;
  end

  // word is held stable while pending, so reader may sample it directly
  assign mail_o   = mail_q;
  assign wflag_no = ~full_w;
  assign rflag_no = ~full_r;

  AST_WR_SETS_FLAG: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_i && !full_w) |=> full_w); // R2
  AST_NO_OVERWRITE: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_i && full_w) |=> $stable(mail_q)); // R3
  AST_RD_CLEARS: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_i && full_r) |=> !full_r); // R4
  AST_FLAG_HOLDS: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!rd_i && full_r) |=> full_r); // R4
endmodule

// File: rtl/mbox_pair.sv
`timescale 1ns/1ps
module mbox_pair #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              clk_c_i,
  input  logic              mb1_rst_ni,
  input  logic              mb2_rst_ni,
  input  logic              a_wr_i,
  input  logic              a_rd_i,
  input  logic              a_mbx_sel_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic [DATA_W-1:0] a_fifo_rdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  output logic              a_fifo_wr_o,
  output logic              a_fifo_rd_o,
  output logic              mb1_flag_a_no,
  output logic              mb2_flag_a_no,
  input  logic              b_rd_i,
  input  logic              b_mbx_sel_i,
  input  logic [DATA_W-1:0] b_fifo_rdata_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              b_fifo_rd_o,
  output logic              mb1_flag_b_no,
  input  logic              c_wr_i,
  input  logic              c_mbx_sel_i,
  input  logic [DATA_W-1:0] c_wdata_i,
  output logic              c_fifo_wr_o,
  output logic              mb2_flag_c_no
);
  logic [DATA_W-1:0] mail1, mail2;

  mbox_channel #(.DATA_W(DATA_W)) u_mail1 (
    .wclk_i  (clk_a_i),
    .rclk_i  (clk_b_i),
    .rst_ni  (mb1_rst_ni),
    .wr_i    (a_wr_i & a_mbx_sel_i),
    .wdata_i (a_wdata_i),
    .rd_i    (b_rd_i & b_mbx_sel_i),
    .mail_o  (mail1),
    .wflag_no(mb1_flag_a_no),
    .rflag_no(mb1_flag_b_no)
  );

  mbox_channel #(.DATA_W(DATA_W)) u_mail2 (
    .wclk_i  (clk_c_i),
    .rclk_i  (clk_a_i),
    .rst_ni  (mb2_rst_ni),
    .wr_i    (c_wr_i & c_mbx_sel_i),
    .wdata_i (c_wdata_i),
    .rd_i    (a_rd_i & a_mbx_sel_i),
    .mail_o  (mail2),
    .wflag_no(mb2_flag_c_no),
    .rflag_no(mb2_flag_a_no)
  );

  assign a_fifo_wr_o = a_wr_i & ~a_mbx_sel_i;
  assign a_fifo_rd_o = a_rd_i & ~a_mbx_sel_i;
  assign b_fifo_rd_o = b_rd_i & ~b_mbx_sel_i;
  assign c_fifo_wr_o = c_wr_i & ~c_mbx_sel_i;

  assign a_rdata_o = a_mbx_sel_i ? mail2 : a_fifo_rdata_i;
  assign b_rdata_o = b_mbx_sel_i ? mail1 : b_fifo_rdata_i;
endmodule

// File: tb/tb_mbox_pair.sv
`timescale 1ns/1ps
module tb_mbox_pair;
  localparam int W = 32;

  logic clk_a = 0, clk_b = 0, clk_c = 0;
  logic mb1_rst_n = 0, mb2_rst_n = 0;
  logic a_wr = 0, a_rd = 0, a_sel = 0;
  logic [W-1:0] a_wdata = '0, a_fifo_rdata = '0, a_rdata;
  logic a_fifo_wr, a_fifo_rd, mb1_fa, mb2_fa;
  logic b_rd = 0, b_sel = 0;
  logic [W-1:0] b_fifo_rdata = '0, b_rdata;
  logic b_fifo_rd, mb1_fb;
  logic c_wr = 0, c_sel = 0;
  logic [W-1:0] c_wdata = '0;
  logic c_fifo_wr, mb2_fc;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;
  always #4.5 clk_c = ~clk_c;

  mbox_pair #(.DATA_W(W)) dut (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .clk_c_i(clk_c),
    .mb1_rst_ni(mb1_rst_n), .mb2_rst_ni(mb2_rst_n),
    .a_wr_i(a_wr), .a_rd_i(a_rd), .a_mbx_sel_i(a_sel),
    .a_wdata_i(a_wdata), .a_fifo_rdata_i(a_fifo_rdata), .a_rdata_o(a_rdata),
    .a_fifo_wr_o(a_fifo_wr), .a_fifo_rd_o(a_fifo_rd),
    .mb1_flag_a_no(mb1_fa), .mb2_flag_a_no(mb2_fa),
    .b_rd_i(b_rd), .b_mbx_sel_i(b_sel), .b_fifo_rdata_i(b_fifo_rdata),
    .b_rdata_o(b_rdata), .b_fifo_rd_o(b_fifo_rd), .mb1_flag_b_no(mb1_fb),
    .c_wr_i(c_wr), .c_mbx_sel_i(c_sel), .c_wdata_i(c_wdata),
    .c_fifo_wr_o(c_fifo_wr), .mb2_flag_c_no(mb2_fc)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic flags(input logic e1a, input logic e1b, input logic e2a, input logic e2c, input string req);
    chk(mb1_fa == e1a, {req, " mb1_flag_a"}, W'(mb1_fa), W'(e1a));
    chk(mb1_fb == e1b, {req, " mb1_flag_b"}, W'(mb1_fb), W'(e1b));
    chk(mb2_fa == e2a, {req, " mb2_flag_a"}, W'(mb2_fa), W'(e2a));
    chk(mb2_fc == e2c, {req, " mb2_flag_c"}, W'(mb2_fc), W'(e2c));
  endtask

  task automatic wait_all();
    repeat (4) @(negedge clk_a);
    repeat (4) @(negedge clk_b);
    repeat (4) @(negedge clk_c);
  endtask

  // side A write; FIFO strobe checked during the strobe
  task automatic a_write(input logic sel, input logic [W-1:0] d);
    @(negedge clk_a);
    a_wr = 1; a_sel = sel; a_wdata = d;
    #0.5;
    chk(a_fifo_wr == !sel, "R7 a_fifo_wr", W'(a_fifo_wr), W'(!sel));
    @(negedge clk_a);
    a_wr = 0; a_sel = 0;
  endtask

  task automatic c_write(input logic sel, input logic [W-1:0] d);
    @(negedge clk_c);
    c_wr = 1; c_sel = sel; c_wdata = d;
    #0.5;
    chk(c_fifo_wr == !sel, "R7 c_fifo_wr", W'(c_fifo_wr), W'(!sel));
    @(negedge clk_c);
    c_wr = 0; c_sel = 0;
  endtask

  task automatic b_read(input logic sel, input logic [W-1:0] exp, input string req);
    @(negedge clk_b);
    b_rd = 1; b_sel = sel;
    #0.5;
    chk(b_rdata == exp, {req, " b_rdata"}, b_rdata, exp);
    chk(b_fifo_rd == !sel, "R7 b_fifo_rd", W'(b_fifo_rd), W'(!sel));
    @(negedge clk_b);
    b_rd = 0; b_sel = 0;
  endtask

  task automatic a_read(input logic sel, input logic [W-1:0] exp, input string req);
    @(negedge clk_a);
    a_rd = 1; a_sel = sel;
    #0.5;
    chk(a_rdata == exp, {req, " a_rdata"}, a_rdata, exp);
    chk(a_fifo_rd == !sel, "R7 a_fifo_rd", W'(a_fifo_rd), W'(!sel));
    @(negedge clk_a);
    a_rd = 0; a_sel = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk_a);
    flags(1, 1, 1, 1, "R9 reset");
    mb1_rst_n = 1; mb2_rst_n = 1;
    wait_all();
    flags(1, 1, 1, 1, "R9 after reset");

    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] d1, d2, f;
      d1 = 32'hA5A5_0000 + W'(i) * 32'h0101_0311;
      d2 = ~d1 ^ (W'(i) << 7);
      f  = d1 ^ 32'hFFFF_0000;
      a_fifo_rdata = f ^ 32'h1;
      b_fifo_rdata = f;

      // mailbox 1: A -> B
      a_write(0, ~d1);                      // FIFO path, R7
      chk(mb1_fa == 1, "R7 fifo write keeps flag", W'(mb1_fa), 1);
      a_write(1, d1);                       // R1
      chk(mb1_fa == 0, "R2 mb1 flag A after write", W'(mb1_fa), 0);
      a_write(1, d1 ^ 32'h00FF_FF00);       // blocked, R3
      repeat (4) @(negedge clk_b);
      chk(mb1_fb == 0, "R2 mb1 flag B synced", W'(mb1_fb), 0);
      b_read(0, f, "R6");                   // FIFO read, flag untouched
      chk(mb1_fb == 0, "R6 flag kept", W'(mb1_fb), 0);
      b_read(1, d1, "R3 R4 mail1");
      chk(mb1_fb == 1, "R4 mb1 flag B cleared", W'(mb1_fb), 1);
      repeat (4) @(negedge clk_a);
      chk(mb1_fa == 1, "R4 mb1 flag A released", W'(mb1_fa), 1);
      b_read(1, d1, "R8 empty read mail1");
      repeat (4) @(negedge clk_a);
      chk(mb1_fb == 1 && mb1_fa == 1, "R8 mb1 flags stay high", W'({mb1_fa, mb1_fb}), 3);

      // mailbox 2: C -> A
      c_write(0, ~d2);
      c_write(1, d2);                       // R1
      chk(mb2_fc == 0, "R2 mb2 flag C after write", W'(mb2_fc), 0);
      c_write(1, d2 + 32'h1234);            // blocked, R3
      repeat (4) @(negedge clk_a);
      chk(mb2_fa == 0, "R2 mb2 flag A synced", W'(mb2_fa), 0);
      a_read(0, f ^ 32'h1, "R6");
      chk(mb2_fa == 0, "R6 flag kept", W'(mb2_fa), 0);
      a_read(1, d2, "R3 R5 mail2");
      chk(mb2_fa == 1, "R5 mb2 flag A cleared", W'(mb2_fa), 1);
      repeat (4) @(negedge clk_c);
      chk(mb2_fc == 1, "R5 mb2 flag C released", W'(mb2_fc), 1);
      a_read(1, d2, "R8 empty read mail2");
      repeat (4) @(negedge clk_c);
      chk(mb2_fc == 1 && mb2_fa == 1, "R8 mb2 flags stay high", W'({mb2_fa, mb2_fc}), 3);
    end

    // independent resets with both mailboxes loaded
    a_write(1, 32'h1111_2222);
    c_write(1, 32'h3333_4444);
    wait_all();
    flags(0, 0, 0, 0, "R2 both loaded");
    @(negedge clk_a);
    mb1_rst_n = 0;
    #0.5;
    flags(1, 1, 0, 0, "R9 mb1 reset");
    @(negedge clk_a);
    mb1_rst_n = 1;
    wait_all();
    flags(1, 1, 0, 0, "R9 mb1 reset released");
    @(negedge clk_a);
    mb2_rst_n = 0;
    #0.5;
    flags(1, 1, 1, 1, "R9 mb2 reset");
    @(negedge clk_a);
    mb2_rst_n = 1;
    wait_all();
    flags(1, 1, 1, 1, "R9 mb2 reset released");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_a);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule